// File: doc/BRIEF.md
# Block and Type-Code Generator

This block sits on the transmit side between the MAC-facing parallel bus and the lane distribution logic. Each valid cycle it takes eight bytes plus one data/control flag per byte and turns them into a 64-bit block with a single 4-bit type code. The code replaces the eight per-byte flags. It tells the downstream logic whether the block is pure data, a frame start (at byte 0 or byte 4), a frame end with the terminate character at a known byte, a pure control block, or one of three special blocks: alignment, error and null.

Byte 0 is `tx_data_in[7:0]` and is flagged by `tx_ctl_in[0]`. Byte k is `tx_data_in[8k+7:8k]` and is flagged by `tx_ctl_in[k]`. The control characters are start 0xFB, terminate 0xFD, error 0xFE, alignment 0x7C and null 0x9C. Any other value in a flagged byte is a plain control character, such as idle 0x07. The result is registered, so it appears one clock after the input, with a valid bit travelling alongside.

Any pattern that matches none of the legal shapes is not passed on. It goes out as an error block: type code 1100, with every byte set to 0xFE.

Top module: `blk_type_gen`

## Requirements
- R1: While `rst` is high, at each clock `blk_valid`, `blk_type` and `blk_data` are all cleared to zero.
- R2: `blk_valid` equals `in_valid` from one clock earlier. In a cycle with `in_valid` low, `blk_type` and `blk_data` keep their previous values.
- R3: A block with all flags clear gets type 0000, and its data passes unchanged.
- R4: If the flags are 0x01 and byte 0 is 0xFB, the block gets type 1001 and its data passes unchanged.
- R5: If the flags are 0x1F, byte 4 is 0xFB and bytes 0 to 3 hold neither 0xFB nor 0xFD, the block gets type 1010 and its data passes unchanged.
- R6: A terminate 0xFD at byte p (0 to 7) gets type 8−p, provided three things hold. The flags must be clear below p and set from p upward. Byte p must be 0xFD. No byte above p may be 0xFB or 0xFD. The data passes unchanged.
- R7: All flags set, with no byte equal to 0xFB or 0xFD, and not matching R8, gives type 1111 with data unchanged.
- R8: All flags set with every byte 0x7C gives type 1011 (alignment). Every byte 0x9C gives type 1101 (null). Every byte 0xFE gives type 1100 (error).
- R9: Any other flag/byte pattern is invalid. This includes a start at a byte other than 0 or 4. An invalid pattern gives type 1100 with all eight output bytes 0xFE.
- R10: Type code 1110 is never produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input bytes and flags are valid this cycle |
| tx_data_in | input | 64 | Eight input bytes, byte 0 in bits 7:0 |
| tx_ctl_in | input | 8 | Per-byte control flag, bit k for byte k |
| blk_valid | output | 1 | Output block valid |
| blk_type | output | 4 | Block type code |
| blk_data | output | 64 | Output block data |

## Verification
The properties assume `in_valid`, `tx_data_in` and `tx_ctl_in` are settled before each rising edge and carry defined values whenever reset is low. The stimulus drives them only on falling edges. The properties put no limit on which byte patterns may appear. The stimulus therefore mixes hand-built legal shapes of every type, including each terminate position and both start positions, with slightly corrupted and fully random flag/byte patterns, so that both the classification paths and the invalid path are reached.

// File: rtl/blk_type_pkg.sv
package blk_type_pkg;

  localparam int NBYTES = 8;
  localparam int BYTE_W = 8;
  localparam int CODE_W = 4;

  localparam logic [BYTE_W-1:0] CH_START = 8'hFB;
  localparam logic [BYTE_W-1:0] CH_TERM  = 8'hFD;
  localparam logic [BYTE_W-1:0] CH_ERR   = 8'hFE;
  localparam logic [BYTE_W-1:0] CH_ALIGN = 8'h7C;
  localparam logic [BYTE_W-1:0] CH_NULL  = 8'h9C;

  typedef enum logic [CODE_W-1:0] {
    TY_DATA   = 4'b0000,
    TY_START0 = 4'b1001,
    TY_START4 = 4'b1010,
    TY_ALIGN  = 4'b1011,
    TY_ERROR  = 4'b1100,
    TY_NULL   = 4'b1101,
    TY_RSVD   = 4'b1110,
    TY_CTRL   = 4'b1111
  } blk_type_e;

endpackage

// File: rtl/blk_byte_class.sv
module blk_byte_class #(
  parameter int BYTE_W = 8,
  parameter logic [BYTE_W-1:0] START_CH = 8'hFB,
  parameter logic [BYTE_W-1:0] TERM_CH  = 8'hFD,
  parameter logic [BYTE_W-1:0] ERR_CH   = 8'hFE,
  parameter logic [BYTE_W-1:0] ALIGN_CH = 8'h7C,
  parameter logic [BYTE_W-1:0] NULL_CH  = 8'h9C
) (
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              flag_in,
  output logic              is_start,
  output logic              is_term,
  output logic              is_err,
  output logic              is_align,
  output logic              is_null
);

  // A character only counts when its byte is flagged as control
  always_comb begin
    is_start = flag_in && (byte_in == START_CH);
    is_term  = flag_in && (byte_in == TERM_CH);
    is_err   = flag_in && (byte_in == ERR_CH);
    is_align = flag_in && (byte_in == ALIGN_CH);
    is_null  = flag_in && (byte_in == NULL_CH);
  end

endmodule

// File: rtl/blk_type_decode.sv
module blk_type_decode
  import blk_type_pkg::*;
#(
  parameter int NB = 8,
  parameter int BW = 8,
  parameter int CW = 4,
  parameter logic [BW-1:0] ERR_CH = 8'hFE
) (
  input  logic [NB*BW-1:0] data_in,
  input  logic [NB-1:0]    ctl_in,
  input  logic [NB-1:0]    is_start,
  input  logic [NB-1:0]    is_term,
  input  logic [NB-1:0]    is_err,
  input  logic [NB-1:0]    is_align,
  input  logic [NB-1:0]    is_null,
  output logic [CW-1:0]    type_out,
  output logic [NB*BW-1:0] data_out
);

  localparam int MID = NB / 2;
  localparam logic [NB-1:0] ONE      = NB'(1);
  localparam logic [NB-1:0] S0_MASK  = ONE;
  localparam logic [NB-1:0] S4_MASK  = (ONE << (MID + 1)) - ONE;
  localparam logic [NB-1:0] LOW_MASK = (ONE << MID) - ONE;

  // bytes holding a frame delimiter
  logic [NB-1:0] delim;
  assign delim = is_start | is_term;

  // terminate candidates, one per byte position
  logic [NB-1:0] term_hit;

  for (genvar p = 0; p < NB; p++) begin : g_term
    localparam logic [NB-1:0] FLAG_MASK = {NB{1'b1}} << p;
    localparam logic [NB-1:0] ABOVE     = FLAG_MASK & ~(ONE << p);
    assign term_hit[p] = (ctl_in == FLAG_MASK) && is_term[p] &&
                         ~|(delim & ABOVE);
  end

  logic [CW-1:0] term_code;

  always_comb begin
    term_code = '0;
    for (int p = 0; p < NB; p++) begin
      if (term_hit[p]) term_code = CW'(NB - p);
    end
  end

  logic hit_start0, hit_start4, all_ctl;
  assign hit_start0 = (ctl_in == S0_MASK) && is_start[0];
  assign hit_start4 = (ctl_in == S4_MASK) && is_start[MID] &&
                      ~|(delim & LOW_MASK);
  assign all_ctl    = &ctl_in;

  logic invalid;

  always_comb begin
    type_out = TY_ERROR;
    invalid  = 1'b1;
    if (ctl_in == '0) begin
      type_out = TY_DATA;
      invalid  = 1'b0;
    end else if (hit_start0) begin
      type_out = TY_START0;
      invalid  = 1'b0;
    end else if (hit_start4) begin
      type_out = TY_START4;
      invalid  = 1'b0;
    end else if (|term_hit) begin
      type_out = term_code;
      invalid  = 1'b0;
    end else if (all_ctl) begin
      if (&is_align) begin
        type_out = TY_ALIGN;
        invalid  = 1'b0;
      end else if (&is_null) begin
        type_out = TY_NULL;
        invalid  = 1'b0;
      end else if (&is_err) begin
        type_out = TY_ERROR;
        invalid  = 1'b0;
      end else if (~|delim) begin
        type_out = TY_CTRL;
        invalid  = 1'b0;
      end
    end
  end

  assign data_out = invalid ? {NB{ERR_CH}} : data_in;

endmodule

// File: rtl/blk_out_reg.sv
module blk_out_reg #(
  parameter int W = 68
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic         vld,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= 1'b0;
      q   <= '0;
    end else begin
      vld <= en;
      if (en) q <= d;
    end
  end

endmodule

// File: rtl/blk_type_gen.sv
module blk_type_gen
  import blk_type_pkg::*;
#(
  parameter int NB = NBYTES,
  parameter int BW = BYTE_W,
  parameter int CW = CODE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [NB*BW-1:0] tx_data_in,
  input  logic [NB-1:0]    tx_ctl_in,
  output logic             blk_valid,
  output logic [CW-1:0]    blk_type,
  output logic [NB*BW-1:0] blk_data
);

  localparam int DW = NB * BW;

  logic [NB-1:0] is_start, is_term, is_err, is_align, is_null;

  for (genvar k = 0; k < NB; k++) begin : g_byte
    blk_byte_class #(
      .BYTE_W(BW), .START_CH(CH_START), .TERM_CH(CH_TERM),
      .ERR_CH(CH_ERR), .ALIGN_CH(CH_ALIGN), .NULL_CH(CH_NULL)
    ) u_class (
      .byte_in (tx_data_in[k*BW +: BW]),
      .flag_in (tx_ctl_in[k]),
      .is_start(is_start[k]),
      .is_term (is_term[k]),
      .is_err  (is_err[k]),
      .is_align(is_align[k]),
      .is_null (is_null[k])
    );
  end

  logic [CW-1:0] nxt_type;
  logic [DW-1:0] nxt_data;

  blk_type_decode #(.NB(NB), .BW(BW), .CW(CW), .ERR_CH(CH_ERR)) u_decode (
    .data_in (tx_data_in),
    .ctl_in  (tx_ctl_in),
    .is_start(is_start),
    .is_term (is_term),
    .is_err  (is_err),
    .is_align(is_align),
    .is_null (is_null),
    .type_out(nxt_type),
    .data_out(nxt_data)
  );

  logic [CW+DW-1:0] reg_q;

  blk_out_reg #(.W(CW + DW)) u_oreg (
    .clk(clk),
    .rst(rst),
    .en (in_valid),
    .d  ({nxt_type, nxt_data}),
    .vld(blk_valid),
    .q  (reg_q)
  );

  assign blk_type = reg_q[CW+DW-1:DW];
  assign blk_data = reg_q[DW-1:0];

endmodule

// File: rtl/blk_type_gen_chk.sv
module blk_type_gen_chk
  import blk_type_pkg::*;
#(
  parameter int NB = NBYTES,
  parameter int BW = BYTE_W,
  parameter int CW = CODE_W
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [NB*BW-1:0] tx_data_in,
  input logic [NB-1:0]    tx_ctl_in,
  input logic             blk_valid,
  input logic [CW-1:0]    blk_type,
  input logic [NB*BW-1:0] blk_data
);

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!blk_valid && blk_type == '0 && blk_data == '0));

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> blk_valid);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!blk_valid && $stable(blk_type) && $stable(blk_data)));

  // R3
  data_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && tx_ctl_in == '0) |=>
      (blk_type == TY_DATA && blk_data == $past(tx_data_in)));

  // R4
  start0_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && tx_ctl_in == NB'(1) && tx_data_in[BW-1:0] == CH_START)
      |=> blk_type == TY_START0);

  // R9
  error_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (blk_valid && blk_type == TY_ERROR) |-> blk_data == {NB{CH_ERR}});

  // R10
  no_reserved_chk: assert property (@(posedge clk) disable iff (rst)
    blk_valid |-> blk_type != TY_RSVD);

endmodule

bind blk_type_gen blk_type_gen_chk #(.NB(NB), .BW(BW), .CW(CW)) u_chk (.*);

// File: tb/test_blk_type_gen.sv
module test_blk_type_gen;

  localparam int PERIOD = 10;
  localparam int NRAND  = 4000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] tx_data_in = '0;
  logic [7:0]  tx_ctl_in = '0;
  logic        blk_valid;
  logic [3:0]  blk_type;
  logic [63:0] blk_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic        exp_valid = 1'b0;
  logic [3:0]  exp_type = '0;
  logic [63:0] exp_data = '0;

  always #(PERIOD/2) clk = ~clk;

  blk_type_gen i_blk_type_gen (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .tx_data_in(tx_data_in), .tx_ctl_in(tx_ctl_in),
    .blk_valid(blk_valid), .blk_type(blk_type), .blk_data(blk_data)
  );

  // Behavioural model: returns {type, data}
  function automatic logic [67:0] model(logic [63:0] d, logic [7:0] c);
    logic [7:0] b [8];
    logic [7:0] m;
    bit ok;
    int n_al, n_nu, n_er, n_dl;
    for (int k = 0; k < 8; k++) b[k] = d[8*k +: 8];
    if (c == 8'h00) return {4'h0, d};
    if (c == 8'h01 && b[0] == 8'hFB) return {4'h9, d};
    if (c == 8'h1F && b[4] == 8'hFB) begin
      ok = 1;
      for (int k = 0; k < 4; k++) if (b[k] == 8'hFB || b[k] == 8'hFD) ok = 0;
      if (ok) return {4'hA, d};
    end
    for (int p = 0; p < 8; p++) begin
      m = 8'hFF << p;
      if (c == m && b[p] == 8'hFD) begin
        ok = 1;
        for (int k = p + 1; k < 8; k++) if (b[k] == 8'hFB || b[k] == 8'hFD) ok = 0;
        if (ok) return {4'(8 - p), d};
      end
    end
    if (c == 8'hFF) begin
      n_al = 0; n_nu = 0; n_er = 0; n_dl = 0;
      for (int k = 0; k < 8; k++) begin
        if (b[k] == 8'h7C) n_al++;
        if (b[k] == 8'h9C) n_nu++;
        if (b[k] == 8'hFE) n_er++;
        if (b[k] == 8'hFB || b[k] == 8'hFD) n_dl++;
      end
      if (n_al == 8) return {4'hB, d};
      if (n_nu == 8) return {4'hD, d};
      if (n_er == 8) return {4'hC, d};
      if (n_dl == 0) return {4'hF, d};
    end
    return {4'hC, {8{8'hFE}}};
  endfunction

  function automatic string req_of(logic v, logic [3:0] t);
    if (!v) return "R2";
    case (t)
      4'h0: return "R3";
      4'h9: return "R4";
      4'hA: return "R5";
      4'hF: return "R7";
      4'hB, 4'hD: return "R8";
      4'hC: return "R9";
      default: return "R6";
    endcase
  endfunction

  task automatic check_outputs();
    string r;
    r = req_of(exp_valid, exp_type);
    checks++;
    if (blk_valid !== exp_valid || blk_type !== exp_type || blk_data !== exp_data) begin
      errors++;
      $display("FAIL %s: got v=%0b t=%h d=%h expected v=%0b t=%h d=%h",
               r, blk_valid, blk_type, blk_data, exp_valid, exp_type, exp_data);
    end
    if (blk_valid === 1'b1) begin
      checks++;
      if (blk_type === 4'hE) begin
        errors++;
        $display("FAIL R10: got t=%h expected not e", blk_type);
      end
    end
  endtask

  // one cycle: check previous result, drive new input, update expectation
  task automatic step(logic v, logic [63:0] d, logic [7:0] c);
    logic [67:0] r;
    @(negedge clk);
    check_outputs();
    in_valid = v; tx_data_in = d; tx_ctl_in = c;
    exp_valid = v;
    if (v) begin
      r = model(d, c);
      exp_type = r[67:64];
      exp_data = r[63:0];
    end
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  function automatic logic [7:0] ctlchar();
    case ($urandom % 4)
      0: return 8'h07;
      1: return 8'hFB;
      2: return 8'hFD;
      default: return 8'($urandom);
    endcase
  endfunction

  initial begin
    #(PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [63:0] d;
    logic [7:0]  c;
    int p;
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (blk_valid !== 1'b0 || blk_type !== 4'h0 || blk_data !== 64'h0) begin
      errors++;
      $display("FAIL R1: got v=%0b t=%h d=%h expected 0 0 0", blk_valid, blk_type, blk_data);
    end
    rst = 1'b0;

    // R3 all data
    step(1, 64'h0123_4567_89AB_CDEF, 8'h00);
    step(1, 64'hFDFB_FEFD_FB07_FDFB, 8'h00);
    // R4 start at byte 0
    step(1, 64'h1122_3344_5566_77FB, 8'h01);
    // R5 start at byte 4
    step(1, 64'hAABB_CCFB_0707_0707, 8'h1F);
    // R2 idle hold
    step(0, 64'hDEAD_BEEF_0000_0000, 8'hFF);
    step(0, 64'h0, 8'h00);
    // R6 each terminate position
    for (int q = 0; q < 8; q++) begin
      d = rnd64();
      for (int k = 0; k < 8; k++) if (k > q) d[8*k +: 8] = 8'h07;
      d[8*q +: 8] = 8'hFD;
      step(1, d, 8'(8'hFF << q));
    end
    // R7 control, R8 specials
    step(1, {8{8'h07}}, 8'hFF);
    step(1, {8{8'h7C}}, 8'hFF);
    step(1, {8{8'h9C}}, 8'hFF);
    step(1, {8{8'hFE}}, 8'hFF);
    // R9 start at other bytes, bad flags, delimiter in tail
    step(1, 64'h1122_3344_55FB_6677, 8'h02);
    step(1, 64'h1122_FB07_0707_0707, 8'h3F);
    step(1, 64'h07FD_0707_FD11_2233, 8'hF8);
    step(1, 64'h0707_07FB_0707_0707, 8'hFF);
    step(1, 64'h1122_3344_5566_7707, 8'h01);
    step(1, {{7{8'h7C}}, 8'h9C}, 8'hFF);

    // random mix
    for (int i = 0; i < NRAND; i++) begin
      d = rnd64();
      case ($urandom % 9)
        0: c = 8'h00;
        1: begin c = 8'h01; d[7:0] = 8'hFB; end
        2: begin c = 8'h1F; d[39:32] = 8'hFB;
                 for (int k = 0; k < 4; k++) d[8*k +: 8] = ctlchar(); end
        3: begin p = $urandom % 8; c = 8'(8'hFF << p); d[8*p +: 8] = 8'hFD;
                 for (int k = p + 1; k < 8; k++) d[8*k +: 8] = ctlchar(); end
        4: begin c = 8'hFF;
                 case ($urandom % 4)
                   0: d = {8{8'h7C}};
                   1: d = {8{8'h9C}};
                   2: d = {8{8'hFE}};
                   default: for (int k = 0; k < 8; k++) d[8*k +: 8] = ctlchar();
                 endcase
           end
        5: begin c = 8'($urandom); p = $urandom % 8; d[8*p +: 8] = 8'hFB; end
        default: c = 8'($urandom);
      endcase
      step(($urandom % 8) != 0, d, c);
    end
    step(0, 64'h0, 8'h00);
    step(0, 64'h0, 8'h00);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule